// File: doc/BRIEF.md
# USB Endpoint OUT/SETUP Handshake Responder

This block chooses the reply that a USB function endpoint sends after a host-to-function data phase. A token strobe tells it whether the transaction just opened is an OUT, a SETUP or something else. The data strobe that follows delivers the data packet's PID and a flag that says whether the packet's CRC was good. The block uses these together with the endpoint's type (control or not) and its halted and buffer-ready flags. From them it sets a registered one-cycle handshake select, a data-accept strobe and the endpoint's data toggle.

An OUT is answered with STALL, NAK or ACK, in that order of priority. An ACK stores the data only when its data PID matches the expected toggle. A SETUP on a control endpoint ignores the halted and busy state: it is always acknowledged and accepted, and it resynchronises the toggle. A SETUP on any other endpoint is dropped in silence. A corrupted packet gets no reply. Every silent outcome raises a separate no-response pulse so that the transmitter stays idle.

Top module: `usb_hs_responder`

## Requirements
- R1: After reset, hs_valid_o, no_resp_o and accept_o are 0 and toggle_o is 0, meaning DATA0 is expected.
- R2: An OUT (token PID 4'b0001) with a good packet on a halted endpoint is answered with STALL (hs_sel_o = 2'b11). The data is not accepted and the toggle is unchanged, whatever the ready flag says.
- R3: An OUT with a good packet on an endpoint that is not halted and not ready is answered with NAK (2'b10). The data is not accepted and the toggle is unchanged.
- R4: An OUT with a good packet on an endpoint that is not halted and is ready is answered with ACK (2'b01). When the data PID matches toggle_o (DATA0 = 4'b0011 for toggle 0, DATA1 = 4'b1011 for toggle 1), accept_o pulses and the toggle flips.
- R5: An ACKed OUT whose data PID does not match toggle_o is still answered with ACK. Its data is discarded (accept_o stays 0) and the toggle is unchanged.
- R6: A data packet with a bad CRC (crc_ok_i = 0) after an OUT or a SETUP gets no handshake. no_resp_o pulses, hs_valid_o and accept_o stay 0, and the toggle is unchanged.
- R7: A SETUP (token PID 4'b1101) with a good packet on a control endpoint is always answered with ACK and accepted, whatever the halted flag, the ready flag, the toggle or the data PID (DATA0 or DATA1). Afterwards toggle_o is 1, so DATA1 is expected next.
- R8: A SETUP on a non-control endpoint gets no handshake. no_resp_o pulses, and accept_o and the toggle do not change.
- R9: A data strobe that is not preceded by an OUT or SETUP token produces no output pulse and leaves the toggle unchanged. This covers a token with any other PID, such as IN = 4'b1001, and a second data strobe after the first.
- R10: Results appear in the cycle after the data strobe and last exactly one cycle. hs_valid_o and no_resp_o are never high together.
- R11: A data packet whose PID is neither DATA0 nor DATA1 is treated as corrupted: no handshake, no_resp_o pulses, and the toggle is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tok_valid_i | input | 1 | Token PID strobe |
| tok_pid_i | input | 4 | Decoded token PID |
| dat_valid_i | input | 1 | Data packet end strobe |
| dat_pid_i | input | 4 | Data packet PID |
| crc_ok_i | input | 1 | Data packet CRC good |
| ep_ctrl_i | input | 1 | Endpoint is a control endpoint |
| ep_halt_i | input | 1 | Endpoint halted |
| ep_ready_i | input | 1 | Endpoint buffer can take data |
| hs_valid_o | output | 1 | Handshake select valid (one cycle) |
| hs_sel_o | output | 2 | 01 ACK, 10 NAK, 11 STALL, 00 none |
| no_resp_o | output | 1 | Transaction ends with no handshake (one cycle) |
| accept_o | output | 1 | Data packet is stored |
| toggle_o | output | 1 | Expected data toggle (0 = DATA0) |

## Verification
Directed runs first walk the OUT priority chain. They apply halted with ready, halted without ready, and busy alone, which shows whether STALL really outranks NAK. Matched and mismatched data PIDs are then sent to a ready endpoint, which separates a flipped toggle from a mere ACK. SETUP is sent to a control endpoint that is halted and busy with either data PID, and to a non-control endpoint, which shows that the override applies only where it should. Random sequences then mix OUT, SETUP, IN and stray data strobes with bad CRCs and bad data PIDs. They check that the silent outcomes and the toggle history agree with a bench model over long runs.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;
  localparam int unsigned PID_W = 4;
  localparam int unsigned HS_W  = 2;

  localparam logic [PID_W-1:0] PID_OUT   = 4'b0001;
  localparam logic [PID_W-1:0] PID_SETUP = 4'b1101;
  localparam logic [PID_W-1:0] PID_DATA0 = 4'b0011;
  localparam logic [PID_W-1:0] PID_DATA1 = 4'b1011;

  typedef enum logic [HS_W-1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_OUT   = 2'b01,
    TK_SETUP = 2'b10
  } tok_e;

  typedef struct packed {
    logic respond;
    hs_e  sel;
    logic accept;
    logic tog_load;
    logic tog_val;
  } verdict_t;
endpackage

// File: rtl/usb_hs_token.sv
module usb_hs_token
  import usb_hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  input  logic [PID_W-1:0] tok_pid_i,
  input  logic             dat_valid_i,
  output tok_e             kind_o
);
  tok_e kind_q;

  // any other token closes the pending phase; a data phase consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kind_q <= TK_NONE;
    else if (tok_valid_i) begin
      case (tok_pid_i)
        PID_OUT:   kind_q <= TK_OUT;
        PID_SETUP: kind_q <= TK_SETUP;
        default:   kind_q <= TK_NONE;
      endcase
    end else if (dat_valid_i) kind_q <= TK_NONE;
  end

  assign kind_o = kind_q;
endmodule

// File: rtl/usb_hs_decide.sv
module usb_hs_decide
  import usb_hs_pkg::*;
(
  input  tok_e             kind_i,
  input  logic [PID_W-1:0] dat_pid_i,
  input  logic             crc_ok_i,
  input  logic             ep_ctrl_i,
  input  logic             ep_halt_i,
  input  logic             ep_ready_i,
  input  logic             tog_i,
  output verdict_t         verdict_o
);
  logic pid_is_data, pid_bit, pkt_good;

  assign pid_is_data = (dat_pid_i == PID_DATA0) || (dat_pid_i == PID_DATA1);
  assign pid_bit     = (dat_pid_i == PID_DATA1);
  assign pkt_good    = crc_ok_i && pid_is_data;

  always_comb begin
    verdict_o = '{respond: 1'b0, sel: HS_NONE, accept: 1'b0, tog_load: 1'b0, tog_val: 1'b0};
    case (kind_i)
      TK_SETUP: begin
        if (pkt_good && ep_ctrl_i) begin
          verdict_o.respond  = 1'b1;
          verdict_o.sel      = HS_ACK;
          verdict_o.accept   = 1'b1;
          verdict_o.tog_load = 1'b1;
          verdict_o.tog_val  = 1'b1;   // next data phase is DATA1
        end
      end
      TK_OUT: begin
        if (pkt_good) begin
          verdict_o.respond = 1'b1;
          if (ep_halt_i)        verdict_o.sel = HS_STALL;
          else if (!ep_ready_i) verdict_o.sel = HS_NAK;
          else begin
            verdict_o.sel = HS_ACK;
            if (pid_bit == tog_i) begin
              verdict_o.accept   = 1'b1;
              verdict_o.tog_load = 1'b1;
              verdict_o.tog_val  = ~tog_i;
            end
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/usb_hs_toggle.sv
module usb_hs_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic val_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tog_o <= 1'b0;
    else if (load_i) tog_o <= val_i;
  end
endmodule

// File: rtl/usb_hs_responder.sv
module usb_hs_responder
  import usb_hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  input  logic [PID_W-1:0] tok_pid_i,
  input  logic             dat_valid_i,
  input  logic [PID_W-1:0] dat_pid_i,
  input  logic             crc_ok_i,
  input  logic             ep_ctrl_i,
  input  logic             ep_halt_i,
  input  logic             ep_ready_i,
  output logic             hs_valid_o,
  output logic [HS_W-1:0]  hs_sel_o,
  output logic             no_resp_o,
  output logic             accept_o,
  output logic             toggle_o
);
  tok_e     kind;
  verdict_t verdict;
  logic     dat_fire;
  logic     hs_valid_q, no_resp_q, accept_q;
  hs_e      hs_sel_q;

  usb_hs_token i_token (
    .clk_i, .rst_ni, .tok_valid_i, .tok_pid_i, .dat_valid_i,
    .kind_o(kind)
  );

  usb_hs_decide i_decide (
    .kind_i(kind), .dat_pid_i, .crc_ok_i, .ep_ctrl_i, .ep_halt_i, .ep_ready_i,
    .tog_i(toggle_o), .verdict_o(verdict)
  );

  assign dat_fire = dat_valid_i && !tok_valid_i && (kind != TK_NONE);

  usb_hs_toggle i_toggle (
    .clk_i, .rst_ni,
    .load_i(dat_fire && verdict.tog_load),
    .val_i (verdict.tog_val),
    .tog_o (toggle_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_valid_q <= 1'b0;
      no_resp_q  <= 1'b0;
      accept_q   <= 1'b0;
      hs_sel_q   <= HS_NONE;
    end else begin
      hs_valid_q <= dat_fire && verdict.respond;
      no_resp_q  <= dat_fire && !verdict.respond;
      accept_q   <= dat_fire && verdict.accept;
      hs_sel_q   <= (dat_fire && verdict.respond) ? verdict.sel : HS_NONE;
    end
  end

  assign hs_valid_o = hs_valid_q;
  assign no_resp_o  = no_resp_q;
  assign accept_o   = accept_q;
  assign hs_sel_o   = hs_sel_q;
endmodule

// File: rtl/usb_hs_responder_chk.sv
module usb_hs_responder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dat_valid_i,
  input logic       hs_valid_o,
  input logic [1:0] hs_sel_o,
  input logic       no_resp_o,
  input logic       accept_o,
  input logic       toggle_o
);
  assert_exclusive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_valid_o && no_resp_o));

  assert_single_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o || no_resp_o) |=> !(hs_valid_o || no_resp_o));

  assert_stall_no_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && hs_sel_o == 2'b11) |-> !accept_o);

  assert_nak_no_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && hs_sel_o == 2'b10) |-> !accept_o);

  assert_accept_needs_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (hs_valid_o && hs_sel_o == 2'b01));

  assert_silent_keeps_toggle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_resp_o |-> (!accept_o && $stable(toggle_o)));

  assert_toggle_moves_on_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_o != $past(toggle_o)) |-> (hs_valid_o && hs_sel_o == 2'b01 && accept_o));

  assert_needs_data_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dat_valid_i) |-> (!hs_valid_o && !no_resp_o));
endmodule

bind usb_hs_responder usb_hs_responder_chk i_chk (.*);

// File: tb/test_usb_hs_responder.sv
`timescale 1ns/1ps
module test_usb_hs_responder;
  localparam logic [3:0] T_OUT = 4'b0001, T_SETUP = 4'b1101, T_IN = 4'b1001;
  localparam logic [3:0] D0 = 4'b0011, D1 = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 1'b0, dat_valid = 1'b0, crc_ok = 1'b1;
  logic ep_ctrl = 1'b0, ep_halt = 1'b0, ep_ready = 1'b0;
  logic [3:0] tok_pid = '0, dat_pid = '0;
  logic hs_valid, no_resp, accept, toggle;
  logic [1:0] hs_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, exp_tog = 1'b0;

  always #4 clk = ~clk;

  usb_hs_responder i_usb_hs_responder (
    .clk_i(clk), .rst_ni(rst_n), .tok_valid_i(tok_valid), .tok_pid_i(tok_pid),
    .dat_valid_i(dat_valid), .dat_pid_i(dat_pid), .crc_ok_i(crc_ok),
    .ep_ctrl_i(ep_ctrl), .ep_halt_i(ep_halt), .ep_ready_i(ep_ready),
    .hs_valid_o(hs_valid), .hs_sel_o(hs_sel), .no_resp_o(no_resp),
    .accept_o(accept), .toggle_o(toggle)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench model of the requirements
  task automatic model(input logic [3:0] tok, input logic [3:0] dp, input bit crc,
                       input bit ctl, input bit hlt, input bit rdy, input bit tg,
                       output bit ev, output int es, output bit enr, output bit ea,
                       output bit etg, output string req);
    bit good;
    good = crc && (dp == D0 || dp == D1);
    ev = 0; es = 0; enr = 0; ea = 0; etg = tg; req = "R9";
    if (tok == T_OUT) begin
      if (!good) begin enr = 1; req = crc ? "R11" : "R6"; end
      else begin
        ev = 1;
        if (hlt)       begin es = 3; req = "R2"; end
        else if (!rdy) begin es = 2; req = "R3"; end
        else begin
          es = 1;
          if ((dp == D1) == tg) begin ea = 1; etg = !tg; req = "R4"; end
          else req = "R5";
        end
      end
    end else if (tok == T_SETUP) begin
      if (!good)     begin enr = 1; req = crc ? "R11" : "R6"; end
      else if (!ctl) begin enr = 1; req = "R8"; end
      else begin ev = 1; es = 1; ea = 1; etg = 1; req = "R7"; end
    end
  endtask

  task automatic txn(input logic [3:0] tok, input logic [3:0] dp, input bit crc,
                     input bit ctl, input bit hlt, input bit rdy);
    bit ev, enr, ea, etg;
    int es;
    string req;
    @(negedge clk);
    tok_valid = 1; tok_pid = tok;
    @(negedge clk);
    tok_valid = 0; dat_valid = 1; dat_pid = dp; crc_ok = crc;
    ep_ctrl = ctl; ep_halt = hlt; ep_ready = rdy;
    model(tok, dp, crc, ctl, hlt, rdy, exp_tog, ev, es, enr, ea, etg, req);
    @(negedge clk);
    dat_valid = 0;
    chk(hs_valid == ev, req, "hs_valid", hs_valid, ev);
    chk(int'(hs_sel) == es, req, "hs_sel", hs_sel, es);
    chk(no_resp == enr, req, "no_resp", no_resp, enr);
    chk(accept == ea, req, "accept", accept, ea);
    chk(toggle == etg, req, "toggle", toggle, etg);
    exp_tog = etg;
    @(negedge clk);
    chk(!hs_valid && !no_resp && !accept, "R10", "pulse after one cycle",
        {hs_valid, no_resp, accept}, 0);
  endtask

  task automatic stray_data(input logic [3:0] dp);
    @(negedge clk);
    dat_valid = 1; dat_pid = dp; crc_ok = 1; ep_ready = 1; ep_ctrl = 1;
    @(negedge clk);
    dat_valid = 0;
    chk(!hs_valid && !no_resp && !accept, "R9", "stray data outputs",
        {hs_valid, no_resp, accept}, 0);
    chk(toggle == exp_tog, "R9", "stray data toggle", toggle, exp_tog);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    chk(!hs_valid && !no_resp && !accept, "R1", "reset outputs", {hs_valid, no_resp, accept}, 0);
    chk(toggle == 0, "R1", "reset toggle", toggle, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // directed corners
    txn(T_OUT, D0, 1, 0, 1, 1);      // R2 stall beats ready
    txn(T_OUT, D0, 1, 0, 1, 0);      // R2 stall beats busy
    txn(T_OUT, D0, 1, 0, 0, 0);      // R3
    txn(T_OUT, D1, 1, 0, 0, 1);      // R5 mismatch
    txn(T_OUT, D0, 1, 0, 0, 1);      // R4 flip to 1
    txn(T_OUT, D1, 1, 0, 0, 1);      // R4 flip to 0
    txn(T_OUT, D0, 0, 0, 0, 1);      // R6
    txn(T_OUT, 4'b0111, 1, 0, 0, 1); // R11
    txn(T_SETUP, D0, 1, 1, 1, 0);    // R7 overrides halt and busy
    txn(T_SETUP, D1, 1, 1, 1, 0);    // R7 either data PID
    txn(T_SETUP, D0, 1, 0, 0, 1);    // R8
    txn(T_SETUP, D0, 0, 1, 0, 1);    // R6 on setup
    txn(T_IN, D0, 1, 1, 0, 1);       // R9 other token
    stray_data(D1);                  // R9
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] tk, dp;
      int r;
      r  = $urandom_range(0, 9);
      tk = (r < 5) ? T_OUT : (r < 8) ? T_SETUP : T_IN;
      r  = $urandom_range(0, 9);
      dp = (r < 9) ? ((r < 5) ? D0 : D1) : 4'($urandom_range(0, 15));
      txn(tk, dp, $urandom_range(0, 7) != 0, 1'($urandom_range(0, 1)),
          $urandom_range(0, 4) == 0, $urandom_range(0, 3) != 0);
      if ($urandom_range(0, 15) == 0) stray_data(D0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule